// File: doc/BRIEF.md
# Display Bias Power Sequencer

This block orders the turn-on and turn-off of a display bias supply set: a controller LDO, a bias boost converter, three bias rails (positive LDO, negative charge pump, reference LDO) and finally a backlight permit. A rising enable level starts power-up. A falling level, or a latched fault, runs the shutdown order. The three bias rails are not chained. Each one starts after its own delay, counted from the boost power-good point. On the way down, each one stops after its own delay, counted from the start of shutdown.

All delays are counted by one shared phase timer. A prescaler produces a tick every half millisecond (`HALF_MS_CLKS` clocks), and the timer restarts whenever the sequencer changes state. Per-rail discharge switches follow the rail enables. A registered power-good flag reports either all rails or one selected rail.

Top module: `dbs_sequencer`

In the requirements, H stands for `HALF_MS_CLKS`, and a delay of d ms lasts 2·d·H clocks. "Edge E" is the clock edge that first samples the triggering input.

## Requirements
- R1: While reset is low and after it, `ctl_en`, `boost_en`, `rail_en`, `bl_en` and `pg_flag` are 0, and `dis_on` equals `dis_cfg`.
- R2: On an enable rise with `ctl_on`=1, `ctl_en` rises at edge E. `boost_en` rises 1 + 2·m·H clocks later, where m ms comes from `ctl_su_code` through the map 0,2,5,10,20,50,100,200 (code 0..7).
- R3: The enable level is `en_pin` OR `en_bit`. With `ctl_on`=0, `boost_en` rises at edge E of the enable rise.
- R4: `rail_en[i]` (0 = positive, 1 = negative, 2 = reference; code i in bits 4i+3..4i of `rail_su_code`) rises 1 + max(2·code·H, min) clocks after edge E of `boost_pg`. min is one half-ms tick for the negative rail and 0 for the others. A rail with `rail_on[i]`=0 never enables.
- R5: `bl_en` = `bl_req` AND permit. The permit starts one edge after every enabled rail has both its enable and its `rail_pg` high, or 1 + 40·H clocks after edge E of `boost_pg` if that comes first. With no rail enabled, the permit starts one edge after the boost-good edge. A request made earlier waits for the permit.
- R6: A low enable level (or a fault) clears `bl_en` at the next edge, before any rail turns off.
- R7: With the shutdown start at edge E+1, `rail_en[i]` falls 2 + 2·sd_i·H clocks after E (`rail_sd_code`, same layout as R4). `boost_en` falls together with the last rail. `ctl_en` falls 1 + 2·m·H clocks after that (m from `ctl_sd_code`, same map as R2). The block then returns to standby.
- R8: `dis_on[i]` = `dis_cfg[i]` AND NOT `rail_en[i]` for i=0..2, and `dis_on[3]` = `dis_cfg[3]` AND NOT `ctl_en`.
- R9: A high `flt_thermal`, `flt_short` or `flt_ocp` runs the R6/R7 shutdown. It is latched, and the block does not restart until a fresh enable rise.
- R10: `pg_flag` (one clock of latency) follows `pg_sel`: 0 = all three rails both enabled and good, so it drops when the first one falls. 1, 2 or 3 = rail 0, 1 or 2 alone, enabled and good.
- R11: An enable fall during power-up aborts it. Only supplies that were turned on are turned off. A boost that never started stays off, and `ctl_en` falls 3 + 2·m·H clocks after edge E of the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable from pin |
| en_bit | input | 1 | Enable from register bit |
| ctl_on | input | 1 | Controller LDO is used |
| rail_on | input | 3 | Bias rails used (0 pos, 1 neg, 2 ref) |
| dis_cfg | input | 4 | Discharge allowed (0..2 rails, 3 controller LDO) |
| ctl_su_code | input | 3 | Controller LDO start-up delay code |
| ctl_sd_code | input | 3 | Controller LDO shutdown delay code |
| rail_su_code | input | 12 | Rail start-up delay codes, 4 bits per rail |
| rail_sd_code | input | 12 | Rail shutdown delay codes, 4 bits per rail |
| boost_pg | input | 1 | Boost reached target |
| rail_pg | input | 3 | Rails reached target |
| flt_thermal | input | 1 | Thermal fault |
| flt_short | input | 1 | Short-circuit fault |
| flt_ocp | input | 1 | Rail over-current fault |
| bl_req | input | 1 | Backlight requested |
| pg_sel | input | 2 | Power-good flag source |
| ctl_en | output | 1 | Controller LDO enable |
| boost_en | output | 1 | Bias boost enable |
| rail_en | output | 3 | Bias rail enables |
| dis_on | output | 4 | Discharge switch enables |
| bl_en | output | 1 | Backlight enable |
| pg_flag | output | 1 | Selected power-good flag |

## Verification
The bench times each enable edge against the boost-good and enable edges. A rail delay counted from the wrong origin, or the negative rail's minimum being dropped, would move that rail's edge. It stimulates a pending backlight request with no rails enabled and with the 20 ms timeout. A design that skipped the deferral would raise the backlight before bias is ready, or never raise it. An abort during the controller delay is a corner case: a design that walked the whole shutdown would pulse the boost on. A held enable after a fault is another: a design that re-armed on the level would restart.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   localparam int N_RAIL   = 3;
   localparam int RAIL_NEG = 1;
   localparam int UNIT_W   = 9;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CTL_UP, ST_BST_UP, ST_RAIL_UP,
      ST_ACTIVE, ST_BL_OFF, ST_RAIL_DN, ST_CTL_DN
   } seq_state_t;

   // controller LDO code -> delay in half-millisecond units
   function automatic logic [UNIT_W-1:0] ctl_code_half(input logic [2:0] code);
      logic [UNIT_W-1:0] r;
      unique case (code)
         3'd0: r = 9'd0;
         3'd1: r = 9'd4;
         3'd2: r = 9'd10;
         3'd3: r = 9'd20;
         3'd4: r = 9'd40;
         3'd5: r = 9'd100;
         3'd6: r = 9'd200;
         default: r = 9'd400;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/dbs_phase_timer.sv
module dbs_phase_timer #(
   parameter int HALF_CLKS = 12000,
   parameter int UNIT_W    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   output logic [UNIT_W-1:0] units
);
   localparam int PW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
   localparam logic [PW-1:0] LAST = PW'(HALF_CLKS - 1);

   if (HALF_CLKS < 1) begin : g_bad_half
      $error("HALF_CLKS must be at least 1");
   end

   logic [PW-1:0] presc;
   logic          tick;

   assign tick = (presc == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc <= '0;
         units <= '0;
      end else if (restart) begin
         presc <= '0;
         units <= '0;
      end else begin
         presc <= tick ? '0 : presc + 1'b1;
         if (tick && units != '1) units <= units + 1'b1;
      end
   end

   // R4/R7: elapsed time never goes backwards inside a phase
   a_r4_units_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> units >= $past(units));
endmodule

// File: rtl/dbs_rail_slot.sv
module dbs_rail_slot #(
   parameter int UNIT_W   = 9,
   parameter int MIN_HALF = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_phase,
   input  logic              dn_phase,
   input  logic              cfg_on,
   input  logic              dis_cfg,
   input  logic [3:0]        su_code,
   input  logic [3:0]        sd_code,
   input  logic [UNIT_W-1:0] units,
   output logic              rail_en,
   output logic              dis_on,
   output logic              pending
);
   localparam logic [UNIT_W-1:0] MIN_U = UNIT_W'(MIN_HALF);

   logic [UNIT_W-1:0] su_raw, tgt_up, tgt_dn;

   assign su_raw = {{(UNIT_W-5){1'b0}}, su_code, 1'b0};
   assign tgt_dn = {{(UNIT_W-5){1'b0}}, sd_code, 1'b0};

   if (MIN_HALF > 0) begin : g_min
      assign tgt_up = (su_raw < MIN_U) ? MIN_U : su_raw;
   end else begin : g_plain
      assign tgt_up = su_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rail_en <= 1'b0;
      else if (up_phase && cfg_on && units >= tgt_up) rail_en <= 1'b1;
      else if (dn_phase && units >= tgt_dn) rail_en <= 1'b0;
   end

   assign pending = rail_en && !(units >= tgt_dn);
   assign dis_on  = dis_cfg && !rail_en;

   // R4: a rail only switches on from the start-up phase and when configured
   a_r4_on_in_up: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_en) |-> $past(up_phase) && $past(cfg_on));
   // R7: a rail only switches off from the shutdown phase
   a_r7_off_in_dn: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rail_en) |-> $past(dn_phase));
endmodule

// File: rtl/dbs_pg_select.sv
module dbs_pg_select #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   sel,
   input  logic [N-1:0] rail_pg,
   input  logic [N-1:0] rail_en,
   output logic         pg_flag
);
   logic [N-1:0] good;
   assign good = rail_pg & rail_en;

   if (N != 3) begin : g_bad_n
      $error("power-good select expects three rails");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pg_flag <= 1'b0;
      else begin
         unique case (sel)
            2'd0: pg_flag <= &good;
            2'd1: pg_flag <= good[0];
            2'd2: pg_flag <= good[1];
            default: pg_flag <= good[2];
         endcase
      end
   end

   // R10: the flag never reports good without some rail good a cycle before
   a_r10_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      pg_flag |-> $past(|good));
endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
   import dbs_pkg::*;
#(
   parameter int HALF_MS_CLKS  = 12000,
   parameter int BL_TIMEOUT_MS = 20,
   parameter int NEG_MIN_HALF  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_pin,
   input  logic                en_bit,
   input  logic                ctl_on,
   input  logic [N_RAIL-1:0]   rail_on,
   input  logic [N_RAIL:0]     dis_cfg,
   input  logic [2:0]          ctl_su_code,
   input  logic [2:0]          ctl_sd_code,
   input  logic [4*N_RAIL-1:0] rail_su_code,
   input  logic [4*N_RAIL-1:0] rail_sd_code,
   input  logic                boost_pg,
   input  logic [N_RAIL-1:0]   rail_pg,
   input  logic                flt_thermal,
   input  logic                flt_short,
   input  logic                flt_ocp,
   input  logic                bl_req,
   input  logic [1:0]          pg_sel,
   output logic                ctl_en,
   output logic                boost_en,
   output logic [N_RAIL-1:0]   rail_en,
   output logic [N_RAIL:0]     dis_on,
   output logic                bl_en,
   output logic                pg_flag
);
   localparam int TO_HALF = 2 * BL_TIMEOUT_MS;
   localparam logic [UNIT_W-1:0] TO_U = UNIT_W'(TO_HALF);

   if (TO_HALF >= (1 << UNIT_W) - 1) begin : g_bad_to
      $error("backlight timeout exceeds timer range");
   end
   if (NEG_MIN_HALF < 0 || NEG_MIN_HALF > 30) begin : g_bad_min
      $error("negative rail minimum out of range");
   end

   seq_state_t        state_q, state_d;
   logic              en_lvl, en_q, en_rise;
   logic              flt_now, flt_lat, go_down;
   logic              restart, ctl_done, timed_out, all_ready;
   logic [UNIT_W-1:0] units, ctl_tgt;
   logic [N_RAIL-1:0] pend;

   assign en_lvl  = en_pin | en_bit;
   assign en_rise = en_lvl & ~en_q;
   assign flt_now = flt_thermal | flt_short | flt_ocp;
   assign go_down = ~en_lvl | flt_lat | flt_now;

   assign ctl_tgt   = ctl_code_half((state_q == ST_CTL_DN) ? ctl_sd_code : ctl_su_code);
   assign ctl_done  = units >= ctl_tgt;
   assign timed_out = units >= TO_U;
   assign all_ready = &(~rail_on | (rail_pg & rail_en));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (en_rise && !flt_now) state_d = ctl_on ? ST_CTL_UP : ST_BST_UP;
         ST_CTL_UP:  if (go_down) state_d = ST_BL_OFF;
                     else if (ctl_done) state_d = ST_BST_UP;
         ST_BST_UP:  if (go_down) state_d = ST_BL_OFF;
                     else if (boost_pg) state_d = ST_RAIL_UP;
         ST_RAIL_UP: if (go_down) state_d = ST_BL_OFF;
                     else if (all_ready || timed_out) state_d = ST_ACTIVE;
         ST_ACTIVE:  if (go_down) state_d = ST_BL_OFF;
         ST_BL_OFF:  state_d = ST_RAIL_DN;
         ST_RAIL_DN: if (pend == '0) state_d = ST_CTL_DN;
         default:    if (!ctl_en || ctl_done) state_d = ST_IDLE;
      endcase
   end

   assign restart = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         en_q     <= 1'b0;
         flt_lat  <= 1'b0;
         ctl_en   <= 1'b0;
         boost_en <= 1'b0;
      end else begin
         state_q <= state_d;
         en_q    <= en_lvl;
         if (flt_now) flt_lat <= 1'b1;
         else if (en_rise) flt_lat <= 1'b0;
         if (state_q == ST_IDLE && state_d == ST_CTL_UP) ctl_en <= 1'b1;
         else if (state_q == ST_CTL_DN && ctl_done) ctl_en <= 1'b0;
         if (restart && state_d == ST_BST_UP) boost_en <= 1'b1;
         else if (restart && state_d == ST_CTL_DN) boost_en <= 1'b0;
      end
   end

   assign bl_en     = (state_q == ST_ACTIVE) && bl_req;
   assign dis_on[N_RAIL] = dis_cfg[N_RAIL] && !ctl_en;

   dbs_phase_timer #(.HALF_CLKS(HALF_MS_CLKS), .UNIT_W(UNIT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(restart), .units(units));

   for (genvar g = 0; g < N_RAIL; g++) begin : g_rail
      dbs_rail_slot #(
         .UNIT_W(UNIT_W),
         .MIN_HALF((g == RAIL_NEG) ? NEG_MIN_HALF : 0)
      ) u_slot (
         .clk(clk), .rst_n(rst_n),
         .up_phase(state_q == ST_RAIL_UP),
         .dn_phase(state_q == ST_RAIL_DN),
         .cfg_on(rail_on[g]), .dis_cfg(dis_cfg[g]),
         .su_code(rail_su_code[4*g +: 4]), .sd_code(rail_sd_code[4*g +: 4]),
         .units(units), .rail_en(rail_en[g]), .dis_on(dis_on[g]), .pending(pend[g]));
   end

   dbs_pg_select #(.N(N_RAIL)) u_pg (
      .clk(clk), .rst_n(rst_n), .sel(pg_sel), .rail_pg(rail_pg),
      .rail_en(rail_en), .pg_flag(pg_flag));

   // R2: the boost never starts ahead of a configured controller LDO
   a_r2_boost_after_ctl: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boost_en) |-> (ctl_en || !ctl_on));
   // R5: backlight only while the bias boost is running
   a_r5_bl_needs_boost: assert property (@(posedge clk) disable iff (!rst_n)
      bl_en |-> boost_en);
   // R6: backlight drops one edge after the enable goes low
   a_r6_bl_first: assert property (@(posedge clk) disable iff (!rst_n)
      !en_lvl |=> !bl_en);
   // R7: no bias rail stays on once the boost is off
   a_r7_boost_last: assert property (@(posedge clk) disable iff (!rst_n)
      !boost_en |-> (rail_en == '0));
   // R9: a fault blocks any new start
   a_r9_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      flt_now |=> !$rose(boost_en) && !$rose(ctl_en));
endmodule

// File: tb/dbs_sequencer_tb_top.sv
`timescale 1ns/1ps
module dbs_sequencer_tb_top;
   localparam int H  = 3;
   localparam int TO = 40 * H;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic en_pin = 0, en_bit = 0, ctl_on = 0, boost_pg = 0, bl_req = 0;
   logic flt_thermal = 0, flt_short = 0, flt_ocp = 0;
   logic [2:0]  rail_on = 0, rail_pg = 0;
   logic [3:0]  dis_cfg = 4'b1111;
   logic [2:0]  ctl_su_code = 0, ctl_sd_code = 0;
   logic [11:0] rail_su_code = 0, rail_sd_code = 0;
   logic [1:0]  pg_sel = 0;
   logic        ctl_en, boost_en, bl_en, pg_flag;
   logic [2:0]  rail_en;
   logic [3:0]  dis_on;

   dbs_sequencer #(.HALF_MS_CLKS(H)) dut_i (
      .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_bit(en_bit), .ctl_on(ctl_on),
      .rail_on(rail_on), .dis_cfg(dis_cfg), .ctl_su_code(ctl_su_code),
      .ctl_sd_code(ctl_sd_code), .rail_su_code(rail_su_code), .rail_sd_code(rail_sd_code),
      .boost_pg(boost_pg), .rail_pg(rail_pg), .flt_thermal(flt_thermal),
      .flt_short(flt_short), .flt_ocp(flt_ocp), .bl_req(bl_req), .pg_sel(pg_sel),
      .ctl_en(ctl_en), .boost_en(boost_en), .rail_en(rail_en), .dis_on(dis_on),
      .bl_en(bl_en), .pg_flag(pg_flag));

   always #2 clk = ~clk;

   longint cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct { int id; bit val; longint at; string req; } ev_t;
   ev_t q[$];
   int n_chk = 0, n_fail = 0;
   bit mon_on = 0;
   bit prev [6];
   string nm [6] = '{"ctl_en", "boost_en", "rail_en[0]", "rail_en[1]", "rail_en[2]", "bl_en"};

   function automatic bit sig_val(int id);
      case (id)
         0: return ctl_en;
         1: return boost_en;
         2: return rail_en[0];
         3: return rail_en[1];
         4: return rail_en[2];
         default: return bl_en;
      endcase
   endfunction

   task automatic push(int id, bit val, longint at, string req);
      ev_t e;
      e.id = id; e.val = val; e.at = at; e.req = req;
      q.push_back(e);
   endtask

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: every output edge must match a queued expectation
   always @(negedge clk) begin
      #1;
      if (mon_on) begin
         for (int i = 0; i < 6; i++) begin
            bit v;
            v = sig_val(i);
            if (v != prev[i]) begin
               int k;
               k = -1;
               foreach (q[j]) if (k < 0 && q[j].id == i && q[j].val == v) k = j;
               n_chk++;
               if (k < 0) begin
                  n_fail++;
                  $display("FAIL unexpected %s edge (R2..R11) actual=%0d expected=%0d at cycle %0d",
                           nm[i], v, prev[i], cyc);
               end else begin
                  longint d;
                  d = cyc - q[k].at;
                  if (d > 2 || d < -2) begin
                     n_fail++;
                     $display("FAIL %s %s->%0d cycle actual=%0d expected=%0d",
                              q[k].req, nm[i], v, cyc, q[k].at);
                  end
                  q.delete(k);
               end
               prev[i] = v;
            end
         end
      end
   end

   task automatic drain();
      foreach (q[j]) begin
         n_chk++; n_fail++;
         $display("FAIL %s %s->%0d missing actual=none expected=%0d",
                  q[j].req, nm[q[j].id], q[j].val, q[j].at);
      end
      q.delete();
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_for(int id, bit v);
      int g;
      g = 0;
      while (sig_val(id) != v && g < 5000) begin
         @(negedge clk);
         g++;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(200000 * 4);
      n_fail++; n_chk++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      longint r;
      #1 rst_n = 1'b0;
      step(3);
      // R1: reset state
      check(ctl_en == 0 && boost_en == 0 && bl_en == 0, "R1", "enables in reset", 1, 0);
      check(rail_en == 0, "R1", "rail_en in reset", int'(rail_en), 0);
      check(dis_on == dis_cfg, "R1", "dis_on in reset", int'(dis_on), int'(dis_cfg));
      rst_n = 1'b1;
      step(2);
      check(pg_flag == 0 && rail_en == 0, "R1", "idle after reset", int'(pg_flag), 0);
      for (int i = 0; i < 6; i++) prev[i] = sig_val(i);
      mon_on = 1;

      // Scenario A: full tree start-up and shutdown
      ctl_on = 1; ctl_su_code = 3'd2; ctl_sd_code = 3'd1; rail_on = 3'b111;
      rail_su_code = {4'd3, 4'd0, 4'd1}; rail_sd_code = {4'd1, 4'd0, 4'd2};
      bl_req = 1; step(1);
      en_pin = 1; r = cyc;
      push(0, 1, r + 1, "R2"); push(1, 1, r + 2 + 10 * H, "R2");
      wait_for(1, 1);
      boost_pg = 1; r = cyc;
      push(3, 1, r + 2 + 1 * H, "R4"); push(2, 1, r + 2 + 2 * H, "R4");
      push(4, 1, r + 2 + 6 * H, "R4");
      wait_for(4, 1); step(1);
      check(dis_on == 4'b0000, "R8", "dis_on all up", int'(dis_on), 0);
      check(bl_en == 0, "R5", "bl deferred before pg", int'(bl_en), 0);
      rail_pg = 3'b111; r = cyc;
      push(5, 1, r + 1, "R5");
      step(3);
      check(pg_flag == 1, "R10", "all-rails flag", int'(pg_flag), 1);
      rail_pg[2] = 0; step(2);
      check(pg_flag == 0, "R10", "all-rails flag first fall", int'(pg_flag), 0);
      pg_sel = 2'd1; step(2);
      check(pg_flag == 1, "R10", "positive rail flag", int'(pg_flag), 1);
      pg_sel = 2'd3; step(2);
      check(pg_flag == 0, "R10", "reference rail flag", int'(pg_flag), 0);
      pg_sel = 2'd0; rail_pg = 3'b111; step(2);
      en_pin = 0; r = cyc;
      push(5, 0, r + 1, "R6"); push(3, 0, r + 3, "R7"); push(4, 0, r + 3 + 2 * H, "R7");
      push(2, 0, r + 3 + 4 * H, "R7"); push(1, 0, r + 3 + 4 * H, "R7");
      push(0, 0, r + 4 + 8 * H, "R7");
      wait_for(0, 0); step(3);
      check(dis_on == 4'b1111, "R8", "dis_on all down", int'(dis_on), 15);
      boost_pg = 0; rail_pg = 0; step(2);
      drain();

      // Scenario B: register-bit enable, no controller LDO, no rails
      ctl_on = 0; rail_on = 0; bl_req = 0; dis_cfg = 4'b0101; step(1);
      en_bit = 1; r = cyc;
      push(1, 1, r + 1, "R3");
      wait_for(1, 1);
      boost_pg = 1; step(4);
      check(bl_en == 0, "R5", "no request no backlight", int'(bl_en), 0);
      check(dis_on == 4'b0101, "R8", "dis_on unused rails", int'(dis_on), 5);
      bl_req = 1; r = cyc;
      push(5, 1, r, "R5");
      step(3);
      en_bit = 0; r = cyc;
      push(5, 0, r + 1, "R6"); push(1, 0, r + 3, "R7");
      wait_for(1, 0); step(3);
      boost_pg = 0; step(2);
      drain();

      // Scenario C: timeout-based backlight permit, long rail shutdown
      rail_on = 3'b001; rail_su_code = 0; rail_sd_code = {4'd0, 4'd0, 4'd15};
      dis_cfg = 4'b1111; step(1);
      en_pin = 1; r = cyc;
      push(1, 1, r + 1, "R3");
      wait_for(1, 1);
      boost_pg = 1; r = cyc;
      push(2, 1, r + 2, "R4"); push(5, 1, r + 2 + TO, "R5");
      wait_for(5, 1); step(2);
      en_pin = 0; r = cyc;
      push(5, 0, r + 1, "R6"); push(2, 0, r + 3 + 30 * H, "R7");
      push(1, 0, r + 3 + 30 * H, "R7");
      wait_for(1, 0); step(3);
      boost_pg = 0; step(2);
      drain();

      // Scenario D: abort during the controller LDO delay
      ctl_on = 1; ctl_su_code = 3'd7; ctl_sd_code = 3'd0; rail_on = 3'b111; step(1);
      en_pin = 1; r = cyc;
      push(0, 1, r + 1, "R11");
      step(20);
      en_pin = 0; r = cyc;
      push(0, 0, r + 4, "R11");
      step(50);
      check(boost_en == 0, "R11", "boost never started", int'(boost_en), 0);
      drain();

      // Scenario E: fault shutdown and restart only on a fresh edge
      ctl_on = 0; rail_on = 3'b100; rail_su_code = 0; rail_sd_code = 0; step(1);
      en_pin = 1; r = cyc;
      push(1, 1, r + 1, "R9");
      wait_for(1, 1);
      boost_pg = 1; rail_pg = 3'b100; r = cyc;
      push(4, 1, r + 2, "R4"); push(5, 1, r + 3, "R5");
      step(6);
      flt_thermal = 1; r = cyc;
      push(5, 0, r + 1, "R9"); push(4, 0, r + 3, "R9"); push(1, 0, r + 3, "R9");
      step(1); flt_thermal = 0;
      step(30);
      check(boost_en == 0, "R9", "no restart while enable held", int'(boost_en), 0);
      boost_pg = 0; rail_pg = 0;
      en_pin = 0; step(3);
      en_pin = 1; r = cyc;
      push(1, 1, r + 1, "R9");
      step(4);
      en_pin = 0; r = cyc;
      push(1, 0, r + 3, "R9");
      step(10);
      drain();

      summary();
      $finish;
   end
endmodule